// File: doc/BRIEF.md
# HDLC Transmit Stop and Restart Sequencer

This block decides when a serial HDLC transmit channel may look for new work, and how it stops. While the channel runs, it checks the current transmit descriptor at a fixed interval of transmit clocks. A transmit-on-demand request makes it check at once. When a check finds the descriptor ready, the block fetches it. It works beside a serializer, which reports whether a frame is on the line and pulses once for every bit it shifts out.

There are two ways to stop. The abrupt stop cuts a frame short within a bounded number of bits. It flushes the transmit FIFO and has an abort pattern of 0x7F sent. The descriptor pointer does not advance. The graceful stop lets the current frame finish, then sets a sticky event flag. After either stop, the channel stays halted until it gets a restart command and the next descriptor is marked ready. While halted, the line carries flags or all-ones idle, chosen by a mode input.

Top module: `hdlc_tx_stop_ctrl`

## Requirements
- R1: While running and enabled with no frame active, `poll_o` pulses once every `POLL_CYCLES` clocks. A frame in progress or a low `enable_i` clears the interval count.
- R2: `tod_i` in an eligible running cycle produces a `poll_o` pulse at the next edge and restarts the interval count.
- R3: `fetch_o` pulses together with `poll_o` exactly when `desc_ready_i` is high in the polling cycle. `fetch_o` never pulses without `poll_o`.
- R4: An abrupt stop given while a frame is active pulses `abort_send_o` and `fifo_flush_o` together. This happens at the edge where `frame_active_i` is seen low, or at the `ABORT_BITS`-th `bit_sent_i` strobe after the stop, whichever comes first. `abort_code_o` is always 8'h7F.
- R5: An abrupt stop given with no frame active flushes the FIFO and enters the stopped state at the next edge, with no abort pulse.
- R6: A graceful stop enters the stopped state and sets `gra_event_o` at the edge where no frame is active. That edge is at once if the channel is idle, otherwise at the end of the frame.
- R7: `gra_event_o` stays set until a cycle with `gra_clr_i` high. A new set in the same cycle as a clear wins over the clear.
- R8: While stopped or armed, `poll_o` stays low, except for the resume poll of R9.
- R9: A restart while stopped arms the channel. The channel resumes, with `poll_o` and `fetch_o` pulsing, at the first edge where it is armed and `desc_ready_i` is high. A restart while running is ignored.
- R10: Abrupt stop and graceful stop in the same cycle act as an abrupt stop alone, and the event flag is not set.
- R11: `fill_idle_o` equals `stopped_o AND idle_mode_i`, where 1 selects all-ones idle and 0 selects flags.
- R12: An abrupt or graceful stop while armed returns the channel to stopped without resuming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | transmit clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| enable_i | input | 1 | channel transmit enable |
| tod_i | input | 1 | transmit-on-demand request |
| stop_i | input | 1 | abrupt stop command |
| gstop_i | input | 1 | graceful stop command |
| restart_i | input | 1 | restart command |
| desc_ready_i | input | 1 | current descriptor is ready |
| frame_active_i | input | 1 | serializer has a frame on the line |
| bit_sent_i | input | 1 | serializer shifted one bit |
| idle_mode_i | input | 1 | stopped line fill: 1 idle, 0 flags |
| gra_clr_i | input | 1 | write-one-to-clear for the event flag |
| poll_o | output | 1 | descriptor check pulse |
| fetch_o | output | 1 | descriptor fetch pulse |
| fifo_flush_o | output | 1 | transmit FIFO flush pulse |
| abort_send_o | output | 1 | send abort pattern pulse |
| abort_code_o | output | 8 | abort pattern value |
| stopped_o | output | 1 | channel halted (stopped or armed) |
| gra_event_o | output | 1 | sticky graceful-stop event |
| fill_idle_o | output | 1 | line fill select |

## Verification
Every pulse output and every change of state is registered. Each result therefore appears one clock after the edge that samples its cause. `fill_idle_o` is the exception: it also follows `idle_mode_i` without delay. The bench drives inputs on the falling edge and samples 1 time unit later. It holds a behavioural model that advances on each rising edge from the same sampled inputs, so every output is compared in the cycle it is due. The abort bound is counted by the model, stated in the requirements, in bit strobes and not in clocks. The scenarios space those strobes apart and also run them back to back.

// File: rtl/hdlc_tx_stop_pkg.sv
package hdlc_tx_stop_pkg;
  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_GDRAIN = 3'd1,
    ST_ABORT  = 3'd2,
    ST_HALT   = 3'd3,
    ST_ARMED  = 3'd4
  } tx_state_e;

  localparam logic [7:0] ABORT_PATTERN = 8'h7F;
endpackage

// File: rtl/hdlc_poll_timer.sv
module hdlc_poll_timer #(
  parameter int unsigned POLL_CYCLES = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tod_i,
  output logic due_o
);
  localparam int unsigned CW = (POLL_CYCLES > 1) ? $clog2(POLL_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(POLL_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign due_o = run_i && (tod_i || (cnt_q == LAST));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!run_i)   cnt_q <= '0;
    else if (due_o)    cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/hdlc_abort_window.sv
module hdlc_abort_window #(
  parameter int unsigned ABORT_BITS = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic count_i,
  input  logic bit_i,
  output logic last_o
);
  localparam int unsigned CW = (ABORT_BITS > 1) ? $clog2(ABORT_BITS) : 1;
  localparam logic [CW-1:0] LAST = CW'(ABORT_BITS - 1);

  logic [CW-1:0] cnt_q;

  // asserted on the strobe that completes the bound
  assign last_o = count_i && bit_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!count_i) cnt_q <= '0;
    else if (bit_i)    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/hdlc_stop_fsm.sv
module hdlc_stop_fsm
  import hdlc_tx_stop_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      enable_i,
  input  logic      stop_i,
  input  logic      gstop_i,
  input  logic      restart_i,
  input  logic      desc_ready_i,
  input  logic      frame_active_i,
  input  logic      poll_due_i,
  input  logic      abort_last_i,
  input  logic      gra_clr_i,
  output tx_state_e state_o,
  output logic      poll_o,
  output logic      fetch_o,
  output logic      flush_o,
  output logic      abort_o,
  output logic      gra_event_o
);
  tx_state_e state_q, state_d;
  logic poll_d, fetch_d, flush_d, abort_d, ev_set;
  logic poll_q, fetch_q, flush_q, abort_q, ev_q;

  always_comb begin
    state_d = state_q;
    poll_d  = 1'b0;
    fetch_d = 1'b0;
    flush_d = 1'b0;
    abort_d = 1'b0;
    ev_set  = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (stop_i) begin
          if (frame_active_i) state_d = ST_ABORT;
          else begin
            state_d = ST_HALT;
            flush_d = 1'b1;
          end
        end else if (gstop_i) begin
          if (frame_active_i) state_d = ST_GDRAIN;
          else begin
            state_d = ST_HALT;
            ev_set  = 1'b1;
          end
        end else if (enable_i && !frame_active_i && poll_due_i) begin
          poll_d  = 1'b1;
          fetch_d = desc_ready_i;
        end
      end
      ST_GDRAIN: begin
        if (stop_i) begin
          if (frame_active_i) state_d = ST_ABORT;
          else begin
            state_d = ST_HALT;
            flush_d = 1'b1;
          end
        end else if (!frame_active_i) begin
          state_d = ST_HALT;
          ev_set  = 1'b1;
        end
      end
      ST_ABORT: begin
        if (!frame_active_i || abort_last_i) begin
          state_d = ST_HALT;
          abort_d = 1'b1;
          flush_d = 1'b1;
        end
      end
      ST_HALT: begin
        if (restart_i) state_d = ST_ARMED;
      end
      ST_ARMED: begin
        if (stop_i || gstop_i) state_d = ST_HALT;
        else if (desc_ready_i) begin
          state_d = ST_RUN;
          poll_d  = 1'b1;
          fetch_d = 1'b1;
        end
      end
      default: state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      poll_q  <= 1'b0;
      fetch_q <= 1'b0;
      flush_q <= 1'b0;
      abort_q <= 1'b0;
      ev_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      poll_q  <= poll_d;
      fetch_q <= fetch_d;
      flush_q <= flush_d;
      abort_q <= abort_d;
      ev_q    <= ev_set | (ev_q & ~gra_clr_i);
    end
  end

  assign state_o     = state_q;
  assign poll_o      = poll_q;
  assign fetch_o     = fetch_q;
  assign flush_o     = flush_q;
  assign abort_o     = abort_q;
  assign gra_event_o = ev_q;
endmodule

// File: rtl/hdlc_tx_stop_ctrl.sv
module hdlc_tx_stop_ctrl
  import hdlc_tx_stop_pkg::*;
#(
  parameter int unsigned POLL_CYCLES = 256,
  parameter int unsigned ABORT_BITS  = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       enable_i,
  input  logic       tod_i,
  input  logic       stop_i,
  input  logic       gstop_i,
  input  logic       restart_i,
  input  logic       desc_ready_i,
  input  logic       frame_active_i,
  input  logic       bit_sent_i,
  input  logic       idle_mode_i,
  input  logic       gra_clr_i,
  output logic       poll_o,
  output logic       fetch_o,
  output logic       fifo_flush_o,
  output logic       abort_send_o,
  output logic [7:0] abort_code_o,
  output logic       stopped_o,
  output logic       gra_event_o,
  output logic       fill_idle_o
);
  tx_state_e state;
  logic      poll_due, abort_last, tmr_run, win_count;

  assign tmr_run   = (state == ST_RUN) && enable_i && !frame_active_i;
  assign win_count = (state == ST_ABORT);

  hdlc_poll_timer #(.POLL_CYCLES(POLL_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (tmr_run),
    .tod_i  (tod_i),
    .due_o  (poll_due)
  );

  hdlc_abort_window #(.ABORT_BITS(ABORT_BITS)) u_window (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .count_i (win_count),
    .bit_i   (bit_sent_i),
    .last_o  (abort_last)
  );

  hdlc_stop_fsm u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .enable_i       (enable_i),
    .stop_i         (stop_i),
    .gstop_i        (gstop_i),
    .restart_i      (restart_i),
    .desc_ready_i   (desc_ready_i),
    .frame_active_i (frame_active_i),
    .poll_due_i     (poll_due),
    .abort_last_i   (abort_last),
    .gra_clr_i      (gra_clr_i),
    .state_o        (state),
    .poll_o         (poll_o),
    .fetch_o        (fetch_o),
    .flush_o        (fifo_flush_o),
    .abort_o        (abort_send_o),
    .gra_event_o    (gra_event_o)
  );

  assign stopped_o    = (state == ST_HALT) || (state == ST_ARMED);
  assign fill_idle_o  = stopped_o & idle_mode_i;
  assign abort_code_o = ABORT_PATTERN;
endmodule

// File: rtl/hdlc_tx_stop_chk.sv
module hdlc_tx_stop_chk #(
  parameter int unsigned ABORT_BITS = 64
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       stop_i,
  input logic       frame_active_i,
  input logic       bit_sent_i,
  input logic       gra_clr_i,
  input logic       poll_o,
  input logic       fetch_o,
  input logic       fifo_flush_o,
  input logic       abort_send_o,
  input logic [7:0] abort_code_o,
  input logic       stopped_o,
  input logic       gra_event_o
);
  localparam int unsigned CW = $clog2(ABORT_BITS + 1) + 1;

  logic          pend_q;
  logic [CW-1:0] bits_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      bits_q <= '0;
    end else if (abort_send_o || stopped_o) begin
      pend_q <= 1'b0;
      bits_q <= '0;
    end else if (pend_q) begin
      if (bit_sent_i) bits_q <= bits_q + 1'b1;
    end else if (stop_i && frame_active_i) begin
      pend_q <= 1'b1;
    end
  end

  assert_abort_flushes_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_send_o |-> fifo_flush_o);

  assert_abort_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bits_q <= CW'(ABORT_BITS));

  assert_abort_code_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_code_o == 8'h7F);

  assert_fetch_with_poll_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_o |-> poll_o);

  assert_halt_no_poll_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stopped_o |-> !poll_o);

  assert_event_when_halted_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gra_event_o) |-> stopped_o);

  assert_event_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gra_event_o && !gra_clr_i) |=> gra_event_o);
endmodule

bind hdlc_tx_stop_ctrl hdlc_tx_stop_chk #(.ABORT_BITS(ABORT_BITS)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .stop_i         (stop_i),
  .frame_active_i (frame_active_i),
  .bit_sent_i     (bit_sent_i),
  .gra_clr_i      (gra_clr_i),
  .poll_o         (poll_o),
  .fetch_o        (fetch_o),
  .fifo_flush_o   (fifo_flush_o),
  .abort_send_o   (abort_send_o),
  .abort_code_o   (abort_code_o),
  .stopped_o      (stopped_o),
  .gra_event_o    (gra_event_o)
);

// File: tb/hdlc_tx_stop_ctrl_bench.sv
module hdlc_tx_stop_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int P = 16;
  localparam int A = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic enable_i = 1'b0, tod_i = 1'b0, stop_i = 1'b0, gstop_i = 1'b0;
  logic restart_i = 1'b0, desc_ready_i = 1'b0, frame_active_i = 1'b0;
  logic bit_sent_i = 1'b0, idle_mode_i = 1'b0, gra_clr_i = 1'b0;
  logic poll_o, fetch_o, fifo_flush_o, abort_send_o, stopped_o, gra_event_o, fill_idle_o;
  logic [7:0] abort_code_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hdlc_tx_stop_ctrl #(.POLL_CYCLES(P), .ABORT_BITS(A)) u_hdlc_tx_stop_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .enable_i(enable_i), .tod_i(tod_i),
    .stop_i(stop_i), .gstop_i(gstop_i), .restart_i(restart_i),
    .desc_ready_i(desc_ready_i), .frame_active_i(frame_active_i),
    .bit_sent_i(bit_sent_i), .idle_mode_i(idle_mode_i), .gra_clr_i(gra_clr_i),
    .poll_o(poll_o), .fetch_o(fetch_o), .fifo_flush_o(fifo_flush_o),
    .abort_send_o(abort_send_o), .abort_code_o(abort_code_o),
    .stopped_o(stopped_o), .gra_event_o(gra_event_o), .fill_idle_o(fill_idle_o)
  );

  // behavioural model: 0 run, 1 finishing frame, 2 aborting, 3 halted, 4 armed
  int m_st = 0, m_tmr = 0, m_bits = 0;
  bit m_poll, m_fetch, m_flush, m_abort, m_ev;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 0; m_tmr = 0; m_bits = 0;
      m_poll = 0; m_fetch = 0; m_flush = 0; m_abort = 0; m_ev = 0;
    end else begin
      bit set_ev;
      set_ev = 0;
      m_poll = 0; m_fetch = 0; m_flush = 0; m_abort = 0;
      case (m_st)
        0: begin
          if (stop_i) begin
            m_tmr = 0;
            if (frame_active_i) begin m_st = 2; m_bits = 0; end
            else begin m_st = 3; m_flush = 1; end
          end else if (gstop_i) begin
            m_tmr = 0;
            if (frame_active_i) m_st = 1;
            else begin m_st = 3; set_ev = 1; end
          end else if (enable_i && !frame_active_i) begin
            if (tod_i || m_tmr == P - 1) begin
              m_poll = 1; m_fetch = desc_ready_i; m_tmr = 0;
            end else m_tmr++;
          end else m_tmr = 0;
        end
        1: begin
          if (stop_i) begin
            if (frame_active_i) begin m_st = 2; m_bits = 0; end
            else begin m_st = 3; m_flush = 1; end
          end else if (!frame_active_i) begin m_st = 3; set_ev = 1; end
        end
        2: begin
          if (bit_sent_i) m_bits++;
          if (!frame_active_i || m_bits == A) begin
            m_st = 3; m_abort = 1; m_flush = 1;
          end
        end
        3: if (restart_i) m_st = 4;
        default: begin
          if (stop_i || gstop_i) m_st = 3;
          else if (desc_ready_i) begin
            m_st = 0; m_poll = 1; m_fetch = 1; m_tmr = 0;
          end
        end
      endcase
      m_ev = set_ev ? 1'b1 : (gra_clr_i ? 1'b0 : m_ev);
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_ni && !done) begin
      bit m_halt;
      m_halt = (m_st == 3) || (m_st == 4);
      chk("R1 poll_o (R2 R8 R9)", 8'(poll_o), 8'(m_poll));
      chk("R3 fetch_o", 8'(fetch_o), 8'(m_fetch));
      chk("R4 fifo_flush_o (R5)", 8'(fifo_flush_o), 8'(m_flush));
      chk("R4 abort_send_o", 8'(abort_send_o), 8'(m_abort));
      chk("R4 abort_code_o", abort_code_o, 8'h7F);
      chk("R6 stopped_o (R10 R12)", 8'(stopped_o), 8'(m_halt));
      chk("R7 gra_event_o", 8'(gra_event_o), 8'(m_ev));
      chk("R11 fill_idle_o", 8'(fill_idle_o), 8'(m_halt & idle_mode_i));
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1; @(negedge clk); sig = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cyc(2);
    // reset state
    chk("reset poll_o", 8'(poll_o), 8'h0);
    chk("reset stopped_o", 8'(stopped_o), 8'h0);
    chk("reset gra_event_o", 8'(gra_event_o), 8'h0);
    rst_ni = 1'b1; enable_i = 1'b1;
    cyc(3 * P + 3);                         // R1 periodic polling, nothing ready
    desc_ready_i = 1'b1; cyc(5);
    pulse(tod_i); cyc(4);                   // R2 on demand, R3 fetch
    enable_i = 1'b0; cyc(P + 2); enable_i = 1'b1; cyc(P + 1);   // R1 enable gating
    pulse(restart_i); cyc(3);               // R9 restart while running ignored
    // R4 abrupt stop, frame ends early
    frame_active_i = 1'b1; cyc(3); pulse(stop_i);
    for (int i = 0; i < 3; i++) begin bit_sent_i = 1'b1; cyc(1); bit_sent_i = 1'b0; cyc(1); end
    frame_active_i = 1'b0; cyc(3);
    // R8 halted, R9 restart waits for ready
    desc_ready_i = 1'b0; idle_mode_i = 1'b1; cyc(2 * P);
    idle_mode_i = 1'b0; cyc(2);             // R11
    pulse(restart_i); cyc(4); desc_ready_i = 1'b1; cyc(P + 3);
    // R4 bound reached with back-to-back bits
    frame_active_i = 1'b1; pulse(stop_i);
    bit_sent_i = 1'b1; cyc(A + 3); bit_sent_i = 1'b0; frame_active_i = 1'b0; cyc(2);
    pulse(restart_i); cyc(3);
    // R6 graceful stop while idle, R7 clear and sticky
    pulse(gstop_i); cyc(4); pulse(gra_clr_i); cyc(2);
    pulse(restart_i); cyc(3);
    // R6 graceful stop mid frame
    frame_active_i = 1'b1; cyc(2); pulse(gstop_i); cyc(5); frame_active_i = 1'b0; cyc(3);
    // R7 set beats clear: finish next graceful drain while clearing
    pulse(restart_i); cyc(3);
    frame_active_i = 1'b1; pulse(gstop_i); cyc(2);
    gra_clr_i = 1'b1; frame_active_i = 1'b0; cyc(1); gra_clr_i = 1'b0; cyc(3);
    pulse(gra_clr_i); cyc(2);
    // R10 both stops together mid frame
    pulse(restart_i); cyc(3);
    frame_active_i = 1'b1; stop_i = 1'b1; gstop_i = 1'b1; cyc(1);
    stop_i = 1'b0; gstop_i = 1'b0; cyc(3); frame_active_i = 1'b0; cyc(3);
    // R12 stop while armed
    desc_ready_i = 1'b0; pulse(restart_i); cyc(2); pulse(stop_i); cyc(2);
    desc_ready_i = 1'b1; cyc(3);
    desc_ready_i = 1'b0; pulse(restart_i); cyc(2); pulse(gstop_i); desc_ready_i = 1'b1; cyc(3);
    pulse(restart_i); cyc(3);
    // R5 abrupt stop with no frame, then abrupt stop during graceful drain
    pulse(stop_i); cyc(3); pulse(restart_i); cyc(3);
    frame_active_i = 1'b1; pulse(gstop_i); cyc(2); pulse(stop_i);
    bit_sent_i = 1'b1; cyc(2); bit_sent_i = 1'b0; frame_active_i = 1'b0; cyc(3);
    idle_mode_i = 1'b1; cyc(2);
    finish_run();
  end
endmodule